// File: doc/BRIEF.md
# Buffered Datapath Parameter Commit Unit

This block sits between a host register-write port and a signal datapath. It keeps four datapath parameters: a carrier tuning word, a carrier phase offset, a gain scaling value and an output offset value. Each parameter has two copies. The host writes the buffer copy. The datapath only sees the active copy, which is loaded from the buffer.

A mode flag in the control word decides how buffered values become active. When the flag is set, every completed parameter write reaches its active copy on the next clock edge. When the flag is cleared, parameter writes stay in the buffers. A command bit in the control word then copies all four buffers into the active copies on a single edge, so the datapath never runs on a half-updated set. The command bit clears itself. A one-cycle update pulse tells the datapath that its active parameters changed.

The block also holds a spectral inversion control bit, which selects negated sine data in the datapath. Reads of the parameter addresses return the buffered values, so the host can check what is staged before it commits.

Top module: `param_commit_unit`

## Requirements
- R1: After reset, all buffered and active parameters are zero, the auto-commit flag is 1, the inversion bit is 1 (negated sine selected) and `upd_pulse` is 0.
- R2: With the auto-commit flag set, a write to a parameter address (0x0A tuning word, 0x0B phase, 0x0C gain, 0x0D offset) loads the buffer on the write edge. The active copy follows on the next edge, and `upd_pulse` is high for the cycle after that edge.
- R3: With the auto-commit flag cleared, parameter writes change only the buffers. Active outputs stay unchanged and no pulse is issued.
- R4: Writing 1 to bit 2 of address 0x00 copies all four buffers into the active copies on the edge after the write, in one cycle, together with a one-cycle `upd_pulse`.
- R5: The commit bit clears itself. Reading 0x00 always returns 0 in bit 2, and no further commit happens without a new command write.
- R6: Reading 0x0A to 0x0D returns the buffered value, zero-extended. Reading 0x00 returns the auto-commit flag in bit 1. Reading 0x01 returns the inversion bit in bit 10. All other bits and addresses read 0.
- R7: Bit 1 of a write to 0x00 sets the auto-commit flag. Bit 10 of a write to 0x01 sets the inversion bit, which drives `spec_inv` directly.
- R8: The tuning word keeps 32 bits of write data. The phase, gain and offset parameters keep the low 16 bits, and their upper write bits are dropped.
- R9: A write to an unmapped address changes no output and no readable state, and it raises no pulse.
- R10: An active parameter changes only in a cycle where `upd_pulse` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per completed write |
| wr_addr | input | ADDR_W (8) | Write address |
| wr_data | input | DATA_W (32) | Write data |
| rd_addr | input | ADDR_W (8) | Read address |
| rd_data | output | DATA_W (32) | Combinational read data |
| ftw_q | output | FTW_W (32) | Active tuning word |
| phase_q | output | PH_W (16) | Active phase offset |
| gain_q | output | GAIN_W (16) | Active gain scaling |
| offset_q | output | OFS_W (16) | Active output offset |
| spec_inv | output | 1 | Inversion control, 1 selects negated sine |
| auto_mode | output | 1 | Current auto-commit flag |
| upd_pulse | output | 1 | One-cycle flag, set when active values were just loaded |

## Verification
The assertions check on every cycle that:
- an active copy moves only on a commit edge and then takes its buffer's previous value;
- manual mode never queues a per-parameter commit;
- the commit bit never stays set without a fresh command;
- read bit 2 of the control word is always 0;
- every change of an active value comes with the pulse.

Only the bench scenarios can show the rest: the exact edge where outputs move after a write, the atomic copy of values staged over many writes, truncation of narrow fields, unmapped writes having no effect, and the read map. These are compared against a model of buffers and active copies that the bench keeps under seeded random and directed writes.

// File: rtl/sru_pkg.sv
package sru_pkg;
  localparam int NUM_FIELDS = 4;

  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_MISC  = 8'h01;
  localparam logic [7:0] A_FTW   = 8'h0A;
  localparam logic [7:0] A_PHASE = 8'h0B;
  localparam logic [7:0] A_GAIN  = 8'h0C;
  localparam logic [7:0] A_OFS   = 8'h0D;

  localparam int AUTO_BIT = 1;
  localparam int XFER_BIT = 2;
  localparam int INV_BIT  = 10;

  typedef enum logic [1:0] {F_FTW = 2'd0, F_PHASE = 2'd1, F_GAIN = 2'd2, F_OFS = 2'd3} field_e;

  // One-hot field select for a write address; zero when unmapped.
  function automatic logic [NUM_FIELDS-1:0] field_hit(input logic [7:0] addr);
    logic [NUM_FIELDS-1:0] m;
    m = '0;
    if (addr >= A_FTW && addr <= A_OFS) m[addr - A_FTW] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/sru_ctrl_reg.sv
module sru_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic misc_wr,
  input  logic auto_bit,
  input  logic xfer_bit,
  input  logic inv_bit,
  output logic auto_en,
  output logic spec_inv,
  output logic xfer_pend
);
  logic xfer_cmd;
  assign xfer_cmd = ctrl_wr & xfer_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      auto_en   <= 1'b1;
      spec_inv  <= 1'b1;
      xfer_pend <= 1'b0;
    end else begin
      xfer_pend <= xfer_cmd;
      if (ctrl_wr) auto_en  <= auto_bit;
      if (misc_wr) spec_inv <= inv_bit;
    end
  end

  // R5: the commit bit never lingers without a new command
  p_self_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_pend && !xfer_cmd) |=> !xfer_pend);
endmodule

// File: rtl/sru_commit.sv
module sru_commit #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] fld_wr,
  input  logic         auto_en,
  input  logic         xfer_pend,
  output logic [N-1:0] commit_mask,
  output logic         upd_pulse
);
  logic [N-1:0] fld_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fld_pend  <= '0;
      upd_pulse <= 1'b0;
    end else begin
      fld_pend  <= auto_en ? fld_wr : '0;
      upd_pulse <= |commit_mask;
    end
  end

  assign commit_mask = fld_pend | {N{xfer_pend}};

  // R3: manual mode never queues a per-field commit
  p_manual_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> (fld_pend == '0));
endmodule

// File: rtl/sru_field.sv
module sru_field #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_data,
  input  logic         commit,
  output logic [W-1:0] shadow_q,
  output logic [W-1:0] active_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (ld)     shadow_q <= ld_data;
      if (commit) active_q <= shadow_q;
    end
  end

  // R4: a commit takes the buffer value present at that edge
  p_commit_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (active_q == $past(shadow_q)));
  // R3: without a commit the active copy holds
  p_active_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active_q));
endmodule

// File: rtl/param_commit_unit.sv
module param_commit_unit #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int FTW_W  = 32,
  parameter int PH_W   = 16,
  parameter int GAIN_W = 16,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [FTW_W-1:0]  ftw_q,
  output logic [PH_W-1:0]   phase_q,
  output logic [GAIN_W-1:0] gain_q,
  output logic [OFS_W-1:0]  offset_q,
  output logic              spec_inv,
  output logic              auto_mode,
  output logic              upd_pulse
);
  import sru_pkg::*;

  localparam int NF   = NUM_FIELDS;
  localparam int MAXW = FTW_W;

  function automatic int fw(input int i);
    case (i)
      0:       return FTW_W;
      1:       return PH_W;
      2:       return GAIN_W;
      default: return OFS_W;
    endcase
  endfunction

  logic [7:0]            wa8, ra8;
  logic [NF-1:0]         fld_wr, commit_mask;
  logic                  ctrl_wr, misc_wr, auto_en, xfer_pend;
  logic [NF-1:0][MAXW-1:0] shadow_all, active_all;

  assign wa8     = 8'(wr_addr);
  assign ra8     = 8'(rd_addr);
  assign fld_wr  = wr_en ? field_hit(wa8) : '0;
  assign ctrl_wr = wr_en && (wa8 == A_CTRL);
  assign misc_wr = wr_en && (wa8 == A_MISC);

  sru_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .misc_wr(misc_wr),
    .auto_bit(wr_data[AUTO_BIT]), .xfer_bit(wr_data[XFER_BIT]), .inv_bit(wr_data[INV_BIT]),
    .auto_en(auto_en), .spec_inv(spec_inv), .xfer_pend(xfer_pend)
  );

  sru_commit #(.N(NF)) u_commit (
    .clk(clk), .rst_n(rst_n), .fld_wr(fld_wr), .auto_en(auto_en),
    .xfer_pend(xfer_pend), .commit_mask(commit_mask), .upd_pulse(upd_pulse)
  );

  for (genvar g = 0; g < NF; g++) begin : g_fld
    localparam int W = fw(g);
    sru_field #(.W(W)) u_fld (
      .clk(clk), .rst_n(rst_n), .ld(fld_wr[g]), .ld_data(wr_data[W-1:0]),
      .commit(commit_mask[g]), .shadow_q(shadow_all[g][W-1:0]),
      .active_q(active_all[g][W-1:0])
    );
    if (W < MAXW) begin : g_pad
      assign shadow_all[g][MAXW-1:W] = '0;
      assign active_all[g][MAXW-1:W] = '0;
    end
  end

  assign ftw_q     = active_all[F_FTW][FTW_W-1:0];
  assign phase_q   = active_all[F_PHASE][PH_W-1:0];
  assign gain_q    = active_all[F_GAIN][GAIN_W-1:0];
  assign offset_q  = active_all[F_OFS][OFS_W-1:0];
  assign auto_mode = auto_en;

  always_comb begin
    rd_data = '0;
    case (ra8)
      A_CTRL:  rd_data[AUTO_BIT] = auto_en;
      A_MISC:  rd_data[INV_BIT]  = spec_inv;
      A_FTW:   rd_data = DATA_W'(shadow_all[F_FTW]);
      A_PHASE: rd_data = DATA_W'(shadow_all[F_PHASE]);
      A_GAIN:  rd_data = DATA_W'(shadow_all[F_GAIN]);
      A_OFS:   rd_data = DATA_W'(shadow_all[F_OFS]);
      default: rd_data = '0;
    endcase
  end

  // R5: the command bit never reads back
  p_cmd_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ra8 == A_CTRL) |-> (rd_data[XFER_BIT] == 1'b0));
  // R10: any change of an active value comes with the pulse
  p_change_has_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active_all != $past(active_all)) |-> upd_pulse);
  // R4: a transfer command loads every active copy from its buffer
  p_xfer_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_pend |=> (active_all == $past(shadow_all)));
endmodule

// File: tb/test_param_commit_unit.sv
module test_param_commit_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [31:0] ftw_q;
  logic [15:0] phase_q, gain_q, offset_q;
  logic        spec_inv, auto_mode, upd_pulse;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_sh[4], m_act[4];
  bit m_auto, m_inv;

  always #10 clk = ~clk;

  param_commit_unit i_param_commit_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ftw_q(ftw_q), .phase_q(phase_q),
    .gain_q(gain_q), .offset_q(offset_q), .spec_inv(spec_inv),
    .auto_mode(auto_mode), .upd_pulse(upd_pulse)
  );

  function automatic logic [31:0] fit(input int i, input logic [31:0] d);
    return (i == 0) ? d : {16'h0, d[15:0]};
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a == 8'h00) return {30'h0, m_auto, 1'b0};
    if (a == 8'h01) return {21'h0, m_inv, 10'h0};
    if (a >= 8'h0A && a <= 8'h0D) return m_sh[a - 8'h0A];
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_outs(input string req);
    chk({req, " ftw"},    ftw_q, m_act[0]);
    chk({req, " phase"},  {16'h0, phase_q},  m_act[1]);
    chk({req, " gain"},   {16'h0, gain_q},   m_act[2]);
    chk({req, " offset"}, {16'h0, offset_q}, m_act[3]);
    chk({req, " inv R7"}, {31'h0, spec_inv}, {31'h0, m_inv});
    chk({req, " auto R7"}, {31'h0, auto_mode}, {31'h0, m_auto});
  endtask

  task automatic chk_reads(input string req);
    logic [7:0] al[7] = '{8'h00, 8'h01, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h37};
    foreach (al[k]) begin
      rd_addr = al[k];
      #1;
      chk({req, " read R6"}, rd_data, exp_read(al[k]));
    end
  endtask

  // Write, then follow the edge of the write and the commit edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
    logic [3:0] msk = '0;
    @(negedge clk);
    if (a >= 8'h0A && a <= 8'h0D && m_auto) msk[a - 8'h0A] = 1'b1;
    if (a == 8'h00 && d[2]) msk = 4'hF;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (a >= 8'h0A && a <= 8'h0D) m_sh[a - 8'h0A] = fit(int'(a - 8'h0A), d);
    if (a == 8'h00) m_auto = d[1];
    if (a == 8'h01) m_inv = d[10];
    @(posedge clk); #1 wr_en = 1'b0;
    @(negedge clk);
    chk({req, " pulse before commit R10"}, {31'h0, upd_pulse}, 32'h0);
    chk_outs({req, " pre-commit"});
    for (int i = 0; i < 4; i++) if (msk[i]) m_act[i] = m_sh[i];
    @(negedge clk);
    chk({req, " pulse R2 R4"}, {31'h0, upd_pulse}, {31'h0, |msk});
    chk_outs({req, " post-commit"});
    @(negedge clk);
    chk({req, " pulse one cycle R10"}, {31'h0, upd_pulse}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int i = 0; i < 4; i++) begin m_sh[i] = 0; m_act[i] = 0; end
    m_auto = 1; m_inv = 1;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_outs("R1 reset");
    chk("R1 pulse", {31'h0, upd_pulse}, 32'h0);
    chk_reads("R1");
    // R2 automatic mode, R8 truncation
    wr(8'h0A, 32'hDEADBEEF, "R2 ftw");
    wr(8'h0B, 32'hABCD1234, "R2 R8 phase");
    wr(8'h0C, 32'hFFFF5555, "R8 gain");
    wr(8'h0D, 32'h00017FFF, "R8 offset");
    chk_reads("R2");
    // R3 manual mode
    wr(8'h00, 32'h0, "R3 manual");
    wr(8'h0A, 32'h12345678, "R3 ftw");
    wr(8'h0B, 32'h1111, "R3 phase");
    wr(8'h0C, 32'h2222, "R3 gain");
    wr(8'h0D, 32'h3333, "R3 offset");
    chk_reads("R3 staged");
    // R4 atomic transfer, R5 self clear
    wr(8'h00, 32'h4, "R4 xfer");
    chk_reads("R5 bit2 reads zero");
    repeat (3) @(negedge clk);
    chk("R5 no second pulse", {31'h0, upd_pulse}, 32'h0);
    // R9 unmapped writes
    wr(8'h05, 32'hFFFFFFFF, "R9 unmapped");
    wr(8'h0E, 32'hFFFFFFFF, "R9 unmapped high");
    chk_reads("R9");
    // R7 inversion
    wr(8'h01, 32'h0, "R7 inv clear");
    wr(8'h01, 32'h400, "R7 inv set");
    wr(8'h00, 32'h6, "R4 R7 xfer and auto");
    // random mix
    for (int n = 0; n < 200; n++) begin
      int sel = int'($urandom % 8);
      logic [31:0] d = $urandom;
      case (sel)
        0, 1, 2, 3: wr(8'h0A + 8'(sel), d, "R2 R3 R8 rand field");
        4:          wr(8'h00, d & 32'h6, "R4 R7 rand ctrl");
        5:          wr(8'h01, d, "R7 rand inv");
        6:          wr(8'h20 + 8'(d[3:0]), d, "R9 rand unmapped");
        default:    chk_reads("R6 rand");
      endcase
    end
    chk_reads("R6 final");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule